// File: doc/BRIEF.md
# Edge-Triggered Interrupt Identifier Queue

This block watches a set of interrupt request lines and turns each low-to-high transition into a small numeric identifier. The identifier is the index of the line that rose. Identifiers are queued in first-in first-out order. The processor core learns which sources fired by reading the head of that queue during interrupt service.

When several lines rise in the same cycle, their edges are held as pending. A fixed priority then releases them into the queue one per cycle, lowest line index first. While the queue holds anything, a single interrupt request to the core stays asserted. If the queue is full when an identifier is ready, that identifier is discarded and a sticky overflow flag is raised. Software clears the flag with a dedicated strobe.

Top module: `irqq_top`

## Requirements
- R1: An identifier is produced only for a line sampled low at one clock edge and high at the next. A line held high yields exactly one identifier. Lines are taken as low during reset, so a line that is high when reset is released counts as a rise.
- R2: Line k reports identifier k. The identifier is ceil(log2(NUM_LINES)) bits wide, with a minimum of 1.
- R3: An edge sampled at a clock edge becomes pending. At each later clock edge the pending line with the lowest index is moved into the queue and its pending bit is cleared, one identifier per cycle.
- R4: A new rise on a line whose pending bit is still set merges with that bit, so only one identifier results.
- R5: A rise first sampled at clock edge k appears at the read port after clock edge k+1.
- R6: rd_data_o shows the queue head. When the queue is empty, rd_data_o is 0 and rd_empty_o is 1. A high rd_pop_i at a clock edge removes the head. A pop on an empty queue has no effect.
- R7: irq_o is high exactly when the queue holds at least one identifier.
- R8: An identifier that reaches the queue while it holds DEPTH entries is dropped, even if a pop happens at the same edge. The drop sets ovf_o, which stays high until a cycle with ovf_clr_i high. A drop in the same cycle as the clear leaves ovf_o set.
- R9: Identifiers are read out in the order in which they entered the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Interrupt request lines, one bit per source |
| rd_pop_i | input | 1 | Removes the queue head at the clock edge |
| rd_data_o | output | ID_W | Queue head identifier, 0 when empty |
| rd_empty_o | output | 1 | Queue holds no identifier |
| irq_o | output | 1 | Interrupt request to the core |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| ovf_o | output | 1 | Sticky flag for a dropped identifier |

## Verification
The embedded assertions check on every cycle that a sampled rise always lands in the pending set and that a pending bit disappears only when it is granted. They also check that the queue occupancy never exceeds its depth, moves by one on a lone push or pop, and that a drop raises the overflow flag, which then holds until cleared. Only the bench scenarios can show the end-to-end properties: the lowest-index-first ordering of simultaneous edges, the merging of repeated edges, the two-edge latency to the read port, and the exact identifiers read back. These are compared against a behavioural queue model on every clock.

// File: rtl/irqq_edge.sv
module irqq_edge #(
    parameter int NUM_LINES = 8,
    parameter int ID_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_i,
    output logic                 push_o,
    output logic [ID_W-1:0]      id_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
        logic [NUM_LINES-1:0] pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] grant_oh;
    logic [ID_W-1:0]      sel;

    // lowest pending index wins: scan downward so the last hit is the lowest
    always_comb begin
        sel = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (st_q.pend[i]) sel = ID_W'(i);
        end
    end

    always_comb begin
        rise     = lines_i & ~st_q.prev;
        push_o   = |st_q.pend;
        grant_oh = '0;
        if (push_o) grant_oh[sel] = 1'b1;
        id_o       = sel;
        st_d.prev  = lines_i;
        st_d.pend  = (st_q.pend & ~grant_oh) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RISE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> (($past(rise) & ~st_q.pend) == '0)); // R3

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend != '0) |=> (($past(st_q.pend) & ~$past(grant_oh) & ~st_q.pend) == '0)); // R4

endmodule

// File: rtl/irqq_fifo.sv
module irqq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty_o = (st_q.cnt == '0);
        full_o  = (st_q.cnt == CNT_W'(DEPTH));
        head_o  = empty_o ? '0 : st_q.mem[st_q.rd];
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        st_d    = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr           = nxt(st_q.wr);
        end
        if (do_pop) st_d.rd = nxt(st_q.rd);
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R8

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !(pop_i && !empty_o)) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R9

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o && !(push_i && !full_o)) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R6

endmodule

// File: rtl/irqq_top.sv
module irqq_top #(
    parameter  int NUM_LINES = 8,
    parameter  int DEPTH     = 4,
    localparam int ID_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 rd_pop_i,
    output logic [ID_W-1:0]      rd_data_o,
    output logic                 rd_empty_o,
    output logic                 irq_o,
    input  logic                 ovf_clr_i,
    output logic                 ovf_o
);

    logic            push;
    logic [ID_W-1:0] push_id;
    logic            full;
    logic            drop;
    logic            ovf_d, ovf_q;

    irqq_edge #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines_i),
        .push_o  (push),
        .id_o    (push_id)
    );

    irqq_fifo #(.DEPTH(DEPTH), .W(ID_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (push_id),
        .pop_i   (rd_pop_i),
        .head_o  (rd_data_o),
        .empty_o (rd_empty_o),
        .full_o  (full)
    );

    always_comb begin
        drop  = push && full;
        ovf_d = ovf_clr_i ? 1'b0 : ovf_q;
        if (drop) ovf_d = 1'b1;
        irq_o = !rd_empty_o;
        ovf_o = ovf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf_o); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o); // R8

endmodule

// File: tb/irqq_top_tb.sv
module irqq_top_tb;
    localparam int N     = 8;
    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] lines = '0;
    logic         rd_pop = 1'b0;
    logic         ovf_clr = 1'b0;
    logic [2:0]   rd_data;
    logic         rd_empty, irq, ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irqq_top #(.NUM_LINES(N), .DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_lines_i (lines),
        .rd_pop_i    (rd_pop),
        .rd_data_o   (rd_data),
        .rd_empty_o  (rd_empty),
        .irq_o       (irq),
        .ovf_clr_i   (ovf_clr),
        .ovf_o       (ovf)
    );

    // behavioural reference
    int     m_q[$];
    bit [N-1:0] m_prev, m_pend;
    bit     m_ovf;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.delete(); m_prev = '0; m_pend = '0; m_ovf = 0;
        end else begin
            bit full_b, have;
            int id;
            full_b = (m_q.size() == DEPTH);
            have = 0; id = 0;
            for (int i = 0; i < N; i++) if (!have && m_pend[i]) begin have = 1; id = i; end
            if (have) m_pend[id] = 0;
            if (rd_pop && m_q.size() > 0) void'(m_q.pop_front());
            if (ovf_clr) m_ovf = 0;
            if (have) begin
                if (!full_b) m_q.push_back(id);
                else m_ovf = 1;
            end
            m_pend = m_pend | (lines & ~m_prev);
            m_prev = lines;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // compared every cycle away from the active edge
    always @(negedge clk) if (rst_n && !done) begin
        chk(rd_data, (m_q.size() > 0) ? m_q[0] : 0, "R6 rd_data");
        chk(rd_empty, (m_q.size() == 0), "R6 rd_empty");
        chk(irq, (m_q.size() > 0), "R7 irq");
        chk(ovf, m_ovf, "R8 ovf");
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_expect(input int exp, input string tag);
        chk(rd_data, exp, tag);
        rd_pop = 1'b1;
        tick(1);
        rd_pop = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk(rd_empty, 1, "R6 reset empty");
        chk(irq, 0, "R7 reset irq");
        chk(ovf, 0, "R8 reset ovf");

        // R5 latency and R2 identifier of line 4
        lines = 8'h10; tick(1); lines = '0;
        chk(rd_empty, 1, "R5 not yet after one edge");
        tick(1);
        chk(rd_data, 4, "R5 R2 id after two edges");
        chk(irq, 1, "R7 irq with entry");
        pop_expect(4, "R2 pop line 4");
        chk(rd_empty, 1, "R6 empty after pop");

        // R1 held line gives one identifier
        lines = 8'h04; tick(10); lines = '0; tick(2);
        pop_expect(2, "R1 held line");
        chk(rd_empty, 1, "R1 only one id");

        // R3 simultaneous edges, lowest first
        lines = 8'h4A; tick(1); lines = '0; tick(5);
        pop_expect(1, "R3 first");
        pop_expect(3, "R3 second");
        pop_expect(6, "R3 third");

        // R4 merge while pending
        lines = 8'h83; tick(1); lines = '0; tick(1);
        lines = 8'h80; tick(1); lines = '0; tick(4);
        pop_expect(0, "R4 a");
        pop_expect(1, "R4 b");
        pop_expect(7, "R4 merged");
        chk(rd_empty, 1, "R4 no duplicate");

        // R8 overflow and R9 order
        lines = 8'h3F; tick(1); lines = '0; tick(8);
        chk(ovf, 1, "R8 overflow set");
        pop_expect(0, "R9 o0");
        pop_expect(1, "R9 o1");
        pop_expect(2, "R9 o2");
        pop_expect(3, "R9 o3");
        chk(rd_empty, 1, "R8 dropped ids absent");
        tick(3);
        chk(ovf, 1, "R8 sticky");
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
        chk(ovf, 0, "R8 cleared");

        // R8 drop even with pop at the same edge
        lines = 8'h0F; tick(1); lines = '0; tick(6);
        lines = 8'h40; tick(1); lines = '0; rd_pop = 1'b1; tick(1); rd_pop = 1'b0;
        chk(ovf, 1, "R8 drop with pop");
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
        chk(ovf, 0, "R8 cleared again");

        // R8 set wins over clear
        lines = 8'h30; tick(1); lines = '0; tick(1);
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
        chk(ovf, 1, "R8 set beats clear");
        pop_expect(1, "R9 p1");
        pop_expect(2, "R9 p2");
        pop_expect(3, "R9 p3");
        pop_expect(4, "R9 p4");

        // R6 pop on empty
        rd_pop = 1'b1; tick(2); rd_pop = 1'b0;
        chk(rd_empty, 1, "R6 pop on empty");
        lines = 8'h20; tick(1); lines = '0; tick(1);
        chk(rd_data, 5, "R6 queue intact after empty pop");
        tick(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule